// File: doc/BRIEF.md
# Streaming 5x5 Fixed-Point Convolution Engine

The engine computes a valid-region two-dimensional convolution of one signed fixed-point feature map with a 5x5 kernel. It has three synchronous read ports, one each for the input map, the 25 kernel weights and the output map. Each read port returns data one cycle after the address is presented. It also has one write port, which stores results back into the output map. A start pulse launches a run. The configuration (map width, map height, normalisation shift and element size) is captured when the run is accepted. A one-cycle done pulse closes the run.

For every output position the accumulator is seeded with the value already stored at that output position, shifted left by the normalisation amount. The 25 weighted input pixels are added to it. The sum is then shifted right arithmetically by the same amount. The shifted result is written back to the same location. Because of this seeding, a caller can chain partial sums over several runs, for example one input channel per run. Elements are either signed 16-bit words or signed bytes held in the low 8 bits of each 16-bit memory word.

Top module: `conv5_engine`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `out_wr_en` are 0.
- R2: A run with width W and height H (both at least 5) writes exactly (W-4)*(H-4) results, one for each position with column 0..W-5 and row 0..H-5.
- R3: Results are written at address row*W+col. The column is the outer loop and the row is the inner loop: row runs 0..H-5 for column 0, then again for column 1, and so on.
- R4: Each result is computed as follows. The accumulator starts at the prior output word shifted left by Norm. For kl, kc in 0..4 it adds weight[kl*5+kc] times input[(row+kl)*W+col+kc], in 32-bit two's-complement arithmetic. The sum is then shifted right arithmetically by Norm. Words outside the output region are left unchanged.
- R5: With `cfg_byte`=0, elements are signed 16-bit values and the written word is bits 15:0 of the shifted sum.
- R6: With `cfg_byte`=1, the engine uses only bits 7:0 of every read word, as a signed byte, and ignores bits 15:8. The written word is bits 7:0 of the shifted sum, sign-extended to 16 bits.
- R7: The first write occurs 27 cycles after the clock edge that accepts start. Consecutive writes are exactly 28 cycles apart: 1 cycle for the output read, 25 multiply-accumulate cycles, 1 drain cycle and 1 write cycle.
- R8: `done` is high for exactly one cycle, in the cycle after the last write, and `busy` is 0 in that cycle.
- R9: A start pulse while `busy` is 1 is ignored: the running job's results, count and order are unchanged.
- R10: A start with W<5 or H<5 writes nothing and raises `done` in the cycle after the start edge.
- R11: Configuration inputs are sampled only when start is accepted. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a run (accepted only when idle) |
| cfg_width | input | 8 | Map width W |
| cfg_height | input | 8 | Map height H |
| cfg_norm | input | 5 | Normalisation shift |
| cfg_byte | input | 1 | 1 = signed byte elements, 0 = signed 16-bit elements |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| in_addr | output | 16 | Input map read address |
| in_rdata | input | 16 | Input map read data (one-cycle latency) |
| coef_addr | output | 5 | Weight read address kl*5+kc |
| coef_rdata | input | 16 | Weight read data (one-cycle latency) |
| out_addr | output | 16 | Output map address, shared by read and write |
| out_rdata | input | 16 | Prior output read data (one-cycle latency) |
| out_wr_en | output | 1 | Output write strobe |
| out_wr_data | output | 16 | Result to write |

## Verification
The embedded properties are checked on every cycle. They cover the following: the scan position always lies inside the valid region, and every input and weight address stays within the map and kernel. The accumulator seed never collides with an arriving product. Writes are isolated single cycles and occur only while busy. Done is a single pulse taken while idle. A start during a run leaves the latched configuration untouched. Only the bench scenarios can show that the arithmetic is right: the seed-and-shift chaining, 32-bit wrap, byte-lane selection and truncation, and the exact column-then-row write order. They also show the 27- and 28-cycle timing, the behaviour of degenerate sizes, and that memory words outside the region survive a run.

// File: rtl/conv5_pkg.sv
package conv5_pkg;
  localparam int KSIZE = 5;
  localparam int KTAPS = KSIZE * KSIZE;
  localparam int TAP_W = 3;
  localparam int CIDX_W = 5;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PRE   = 3'd1,
    S_MAC   = 3'd2,
    S_DRAIN = 3'd3,
    S_WRITE = 3'd4
  } conv_state_e;
endpackage

// File: rtl/conv5_ctrl.sv
module conv5_ctrl
  import conv5_pkg::*;
#(
  parameter int DIM_W  = 8,
  parameter int NORM_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  cfg_w,
  input  logic [DIM_W-1:0]  cfg_h,
  input  logic [NORM_W-1:0] cfg_norm,
  input  logic              cfg_byte,
  output logic [DIM_W-1:0]  w_q,
  output logic [DIM_W-1:0]  h_q,
  output logic [NORM_W-1:0] norm_q,
  output logic              byte_q,
  output logic [DIM_W-1:0]  col,
  output logic [DIM_W-1:0]  row,
  output logic [TAP_W-1:0]  kl,
  output logic [TAP_W-1:0]  kc,
  output logic              issue,
  output logic              load,
  output logic              wr,
  output logic              busy,
  output logic              done
);
  localparam logic [TAP_W-1:0] KMAX = TAP_W'(KSIZE - 1);
  localparam logic [DIM_W-1:0] KDIM = DIM_W'(KSIZE);

  conv_state_e state, state_n;
  logic [DIM_W-1:0] col_n, row_n;
  logic [TAP_W-1:0] kl_n, kc_n;
  logic done_n, cfg_en, degen, last_row, last_col;

  assign degen    = (cfg_w < KDIM) || (cfg_h < KDIM);
  assign last_row = (row == (h_q - KDIM));
  assign last_col = (col == (w_q - KDIM));

  always_comb begin
    state_n = state;
    col_n   = col;
    row_n   = row;
    kl_n    = kl;
    kc_n    = kc;
    done_n  = 1'b0;
    cfg_en  = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          if (degen) begin
            done_n = 1'b1;
          end else begin
            cfg_en  = 1'b1;
            col_n   = '0;
            row_n   = '0;
            state_n = S_PRE;
          end
        end
      end
      S_PRE: begin
        kl_n    = '0;
        kc_n    = '0;
        state_n = S_MAC;
      end
      S_MAC: begin
        if (kc == KMAX) begin
          kc_n = '0;
          if (kl == KMAX) state_n = S_DRAIN;
          else            kl_n = kl + 1'b1;
        end else begin
          kc_n = kc + 1'b1;
        end
      end
      S_DRAIN: state_n = S_WRITE;
      S_WRITE: begin
        if (last_row) begin
          row_n = '0;
          if (last_col) begin
            state_n = S_IDLE;
            done_n  = 1'b1;
          end else begin
            col_n   = col + 1'b1;
            state_n = S_PRE;
          end
        end else begin
          row_n   = row + 1'b1;
          state_n = S_PRE;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
      col   <= '0;
      row   <= '0;
      kl    <= '0;
      kc    <= '0;
    end else begin
      state <= state_n;
      done  <= done_n;
      col   <= col_n;
      row   <= row_n;
      kl    <= kl_n;
      kc    <= kc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q    <= '0;
      h_q    <= '0;
      norm_q <= '0;
      byte_q <= 1'b0;
    end else if (cfg_en) begin
      w_q    <= cfg_w;
      h_q    <= cfg_h;
      norm_q <= cfg_norm;
      byte_q <= cfg_byte;
    end
  end

  assign issue = (state == S_MAC);
  assign load  = issue && (kl == '0) && (kc == '0);
  assign wr    = (state == S_WRITE);
  assign busy  = (state != S_IDLE);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_pos_in_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (({1'b0, col} + (DIM_W+1)'(KSIZE) <= {1'b0, w_q}) &&
              ({1'b0, row} + (DIM_W+1)'(KSIZE) <= {1'b0, h_q})));
  p_cfg_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(w_q) && $stable(h_q) && $stable(norm_q) && $stable(byte_q)));
endmodule

// File: rtl/conv5_addr.sv
module conv5_addr
  import conv5_pkg::*;
#(
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [DIM_W-1:0]  w,
  input  logic [DIM_W-1:0]  h,
  input  logic [DIM_W-1:0]  col,
  input  logic [DIM_W-1:0]  row,
  input  logic [TAP_W-1:0]  kl,
  input  logic [TAP_W-1:0]  kc,
  output logic [ADDR_W-1:0] in_addr,
  output logic [CIDX_W-1:0] coef_addr,
  output logic [ADDR_W-1:0] out_addr
);
  logic [ADDR_W-1:0] row_base, tap_row, w_ext;

  assign w_ext    = ADDR_W'(w);
  assign tap_row  = ADDR_W'(row) + ADDR_W'(kl);
  assign row_base = ADDR_W'(tap_row * w_ext);
  assign in_addr  = row_base + ADDR_W'(col) + ADDR_W'(kc);
  assign out_addr = ADDR_W'(ADDR_W'(row) * w_ext) + ADDR_W'(col);
  assign coef_addr = CIDX_W'(CIDX_W'(kl) * CIDX_W'(KSIZE)) + CIDX_W'(kc);

  p_in_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (in_addr < ADDR_W'(w_ext * ADDR_W'(h))));
  p_coef_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (coef_addr < CIDX_W'(KTAPS)));
endmodule

// File: rtl/conv5_mac.sv
module conv5_mac #(
  parameter int DW     = 16,
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 32,
  parameter int NORM_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic [NORM_W-1:0] norm,
  input  logic              issue,
  input  logic              load,
  input  logic [DW-1:0]     in_rdata,
  input  logic [DW-1:0]     coef_rdata,
  input  logic [DW-1:0]     out_rdata,
  output logic [DW-1:0]     wr_data
);
  function automatic logic signed [DW-1:0] lane(input logic [DW-1:0] v, input logic b);
    if (b) lane = {{(DW-BYTE_W){v[BYTE_W-1]}}, v[BYTE_W-1:0]};
    else   lane = v;
  endfunction

  logic                    mac_v;
  logic signed [ACC_W-1:0] acc, acc_n, prod, seed, shifted;
  logic signed [DW-1:0]    px, cx, ox;
  logic                    acc_en;

  assign px   = lane(in_rdata, byte_mode);
  assign cx   = lane(coef_rdata, byte_mode);
  assign ox   = lane(out_rdata, byte_mode);
  assign prod = ACC_W'(px) * ACC_W'(cx);
  assign seed = ACC_W'(ox) <<< norm;

  assign acc_en = load | mac_v;

  always_comb begin
    acc_n = acc;
    if (load)       acc_n = seed;
    else if (mac_v) acc_n = acc + prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mac_v <= 1'b0;
    else        mac_v <= issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (acc_en) acc <= acc_n;
  end

  assign shifted = acc >>> norm;
  assign wr_data = byte_mode ? {{(DW-BYTE_W){shifted[BYTE_W-1]}}, shifted[BYTE_W-1:0]}
                             : shifted[DW-1:0];

  p_seed_no_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && mac_v));
  p_acc_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue && !mac_v) |=> $stable(acc));
endmodule

// File: rtl/conv5_engine.sv
module conv5_engine
  import conv5_pkg::*;
#(
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DW     = 16,
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 32,
  parameter int NORM_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [NORM_W-1:0] cfg_norm,
  input  logic              cfg_byte,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] in_addr,
  input  logic [DW-1:0]     in_rdata,
  output logic [CIDX_W-1:0] coef_addr,
  input  logic [DW-1:0]     coef_rdata,
  output logic [ADDR_W-1:0] out_addr,
  input  logic [DW-1:0]     out_rdata,
  output logic              out_wr_en,
  output logic [DW-1:0]     out_wr_data
);
  logic [DIM_W-1:0]  w_q, h_q, col, row;
  logic [NORM_W-1:0] norm_q;
  logic              byte_q, issue, load, wr;
  logic [TAP_W-1:0]  kl, kc;

  conv5_ctrl #(.DIM_W(DIM_W), .NORM_W(NORM_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_w(cfg_width), .cfg_h(cfg_height), .cfg_norm(cfg_norm), .cfg_byte(cfg_byte),
    .w_q(w_q), .h_q(h_q), .norm_q(norm_q), .byte_q(byte_q),
    .col(col), .row(row), .kl(kl), .kc(kc),
    .issue(issue), .load(load), .wr(wr), .busy(busy), .done(done)
  );

  conv5_addr #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .issue(issue),
    .w(w_q), .h(h_q), .col(col), .row(row), .kl(kl), .kc(kc),
    .in_addr(in_addr), .coef_addr(coef_addr), .out_addr(out_addr)
  );

  conv5_mac #(.DW(DW), .BYTE_W(BYTE_W), .ACC_W(ACC_W), .NORM_W(NORM_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_q), .norm(norm_q),
    .issue(issue), .load(load),
    .in_rdata(in_rdata), .coef_rdata(coef_rdata), .out_rdata(out_rdata),
    .wr_data(out_wr_data)
  );

  assign out_wr_en = wr;

  p_wr_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |=> !out_wr_en);
  p_wr_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> busy);
  p_addr_hold_on_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> $stable(out_addr));
endmodule

// File: tb/tb_conv5_engine.sv
module tb_conv5_engine;
  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [7:0] cfg_width, cfg_height;
  logic [4:0] cfg_norm;
  logic cfg_byte;
  logic busy, done;
  logic [15:0] in_addr, out_addr;
  logic [4:0]  coef_addr;
  logic [15:0] in_rdata, coef_rdata, out_rdata, out_wr_data;
  logic out_wr_en;

  always #10 clk = ~clk;

  conv5_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_norm(cfg_norm), .cfg_byte(cfg_byte),
    .busy(busy), .done(done),
    .in_addr(in_addr), .in_rdata(in_rdata),
    .coef_addr(coef_addr), .coef_rdata(coef_rdata),
    .out_addr(out_addr), .out_rdata(out_rdata),
    .out_wr_en(out_wr_en), .out_wr_data(out_wr_data)
  );

  logic [15:0] in_mem  [0:255];
  logic [15:0] coef_mem[0:24];
  logic [15:0] out_mem [0:255];
  logic [15:0] exp_mem [0:255];

  always @(posedge clk) begin
    in_rdata   <= in_mem[in_addr[7:0]];
    coef_rdata <= coef_mem[(coef_addr < 5'd25) ? coef_addr : 5'd0];
    out_rdata  <= out_mem[out_addr[7:0]];
    if (out_wr_en) out_mem[out_addr[7:0]] <= out_wr_data;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int wr_cnt, first_wr_cyc, last_wr_cyc, gap_bad;
  logic [15:0] wr_log [0:255];

  always @(negedge clk) begin
    if (rst_n && out_wr_en) begin
      if (wr_cnt < 256) wr_log[wr_cnt] = out_addr;
      if (wr_cnt == 0) first_wr_cyc = cyc;
      else if (cyc - last_wr_cyc != 28) gap_bad++;
      last_wr_cyc = cyc;
      wr_cnt++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <150000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] ext(input logic [15:0] v, input bit b);
    return b ? {{8{v[7]}}, v[7:0]} : v;
  endfunction

  int unsigned lcg;
  function automatic logic [15:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[23:8];
  endfunction

  task automatic fill(input int seed);
    lcg = seed;
    for (int i = 0; i < 256; i++) begin
      in_mem[i]  = rnd();
      out_mem[i] = rnd();
      exp_mem[i] = out_mem[i];
    end
    for (int i = 0; i < 25; i++) coef_mem[i] = rnd();
  endtask

  task automatic model(input int w, input int h, input int nrm, input bit b);
    for (int c = 0; c <= w - 5; c++)
      for (int l = 0; l <= h - 5; l++) begin
        int acc;
        logic [31:0] res;
        acc = int'($signed(ext(exp_mem[l*w+c], b))) <<< nrm;
        for (int kl = 0; kl < 5; kl++)
          for (int kc = 0; kc < 5; kc++)
            acc += int'($signed(ext(coef_mem[kl*5+kc], b))) *
                   int'($signed(ext(in_mem[(l+kl)*w+c+kc], b)));
        res = 32'(acc >>> nrm);
        exp_mem[l*w+c] = ext(res[15:0], b);
      end
  endtask

  task automatic launch(input int w, input int h, input int nrm, input bit b, output int s);
    wr_cnt = 0; gap_bad = 0; first_wr_cyc = 0; last_wr_cyc = 0;
    @(negedge clk);
    cfg_width = 8'(w); cfg_height = 8'(h); cfg_norm = 5'(nrm); cfg_byte = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s = cyc;
  endtask

  task automatic run_case(input int w, input int h, input int nrm, input bit b,
                          input int seed, input bit disturb);
    int s, n, lim, k, mism;
    string ltag;
    ltag = b ? "R6 byte result" : "R5 word result";
    fill(seed);
    model(w, h, nrm, b);
    launch(w, h, nrm, b, s);
    if (disturb) begin
      repeat (40) @(negedge clk);
      cfg_width = 8'd6; cfg_height = 8'd6; cfg_norm = 5'd2; cfg_byte = ~b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    lim = 0;
    while (!done && lim < 20000) begin @(negedge clk); lim++; end
    chk(done == 1'b1, "R8 done seen", done, 1);
    chk(busy == 1'b0, "R8 busy low with done", busy, 0);
    chk(last_wr_cyc == cyc - 1, "R8 done follows last write", cyc - last_wr_cyc, 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    n = (w - 4) * (h - 4);
    chk(wr_cnt == n, disturb ? "R9 R2 write count" : "R2 write count", wr_cnt, n);
    chk(first_wr_cyc - s == 27, "R7 first write latency", first_wr_cyc - s, 27);
    chk(gap_bad == 0, "R7 write spacing 28", gap_bad, 0);
    k = 0; mism = 0;
    for (int c = 0; c <= w - 5; c++)
      for (int l = 0; l <= h - 5; l++) begin
        if (k < wr_cnt && k < 256 && wr_log[k] != 16'(l*w + c)) mism++;
        k++;
      end
    chk(mism == 0, "R3 write order", mism, 0);
    for (int i = 0; i < 256; i++)
      chk(out_mem[i] == exp_mem[i], disturb ? "R11 R4 memory word" : ltag, out_mem[i], exp_mem[i]);
  endtask

  localparam logic [31:0] VEC [6] = '{
    {8'd5,  8'd5,  8'd0,  7'd11, 1'b0},
    {8'd8,  8'd6,  8'd3,  7'd22, 1'b0},
    {8'd7,  8'd9,  8'd5,  7'd33, 1'b1},
    {8'd12, 8'd10, 8'd15, 7'd44, 1'b0},
    {8'd6,  8'd5,  8'd31, 7'd55, 1'b1},
    {8'd9,  8'd7,  8'd0,  7'd66, 1'b1}
  };

  task automatic degen_case(input int w, input int h);
    int s;
    fill(w * 7 + h);
    launch(w, h, 1, 1'b0, s);
    chk(done == 1'b1, "R10 done after degenerate start", done, 1);
    chk(busy == 1'b0, "R10 stays idle", busy, 0);
    repeat (40) @(negedge clk);
    chk(wr_cnt == 0, "R10 no writes", wr_cnt, 0);
    for (int i = 0; i < 256; i++)
      chk(out_mem[i] == exp_mem[i], "R10 memory untouched", out_mem[i], exp_mem[i]);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    cfg_width = '0; cfg_height = '0; cfg_norm = '0; cfg_byte = 1'b0;
    wr_cnt = 0; gap_bad = 0;
    for (int i = 0; i < 256; i++) begin in_mem[i] = '0; out_mem[i] = '0; end
    for (int i = 0; i < 25; i++) coef_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && out_wr_en == 1'b0, "R1 reset outputs",
        {busy, done, out_wr_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && out_wr_en == 1'b0, "R1 after release",
        {busy, done, out_wr_en}, 0);

    foreach (VEC[i]) begin
      run_case(int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:8]),
               VEC[i][0], int'(VEC[i][7:1]), 1'b0);
    end

    degen_case(4, 9);
    degen_case(10, 3);
    run_case(8, 7, 4, 1'b0, 77, 1'b1);
    run_case(7, 6, 2, 1'b1, 88, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule